// File: doc/BRIEF.md
# Real-Time Clock Register Bank with Update Guard Window

This block is the byte-wide, memory-mapped front end of a real-time clock. It holds the six calendar fields (seconds through years, all BCD bytes), a six-field alarm, a control byte, a status byte and an interrupt-enable byte. It also divides a slow reference tick down to a once-per-second update strobe. The BCD increment itself lives in a separate calendar core. This bank shows the core its current time on `cal_now`. The core returns the incremented time on `cal_next`, together with rollover flags on `cal_roll`.

Before each once-per-second update, the bank raises a busy status bit for the final reference period of that second. Software reading or writing time fields should first wait for busy to be low. Then it has most of a reference period to work before busy can rise again. The second, minute, hour, day, alarm and power-up flags are sticky, and software clears each one by writing 1 to its bit. Two interrupt lines come out of the bank. The timer line pulses once per second. The alarm line stays high while the alarm flag and its enable are both set.

The parameter `TICKS_PER_SEC` (at least 3) sets how many reference ticks make one second.

Top module: `rtc_regbank`

## Requirements
- R1: After reset, status reads 0x80 (only the power-up flag at bit 7). Control, interrupt enable, all time fields, all alarm fields and both interrupt outputs are 0.
- R2: A register's word index is taken from `bus_addr[7:2]`, and `bus_addr[1:0]` must be 0. The time fields seconds, minutes, hours, day, month and year sit at 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x14. The alarm fields sit at the same offsets plus 0x20. Control is at 0x40, status at 0x44 and interrupt enable at 0x48. Any other offset, including any with nonzero low address bits, reads 0 and ignores writes.
- R3: While control bit 0 (run) is 1, reference ticks are counted. Busy (status bit 0) rises at the clock edge that samples the (TICKS_PER_SEC−1)-th tick of a second. The clock edge that samples the next tick starts the update. At the following clock edge, `cal_next` is loaded into the time fields and busy falls. Clearing run zeroes the count and drops busy at the next edge.
- R4: The status byte is laid out as follows: bit 7 power-up, bit 6 alarm, bit 5 day, bit 4 hour, bit 3 minute, bit 2 second, bit 1 run (a copy of control bit 0), bit 0 busy.
- R5: Writing 1 to any of status bits 7 to 2 clears that flag, and writing 0 leaves it unchanged. A flag set at the same edge wins over the clear. Once cleared, power-up stays 0 until the next reset.
- R6: Every update sets the second flag. It also sets the minute, hour and day flags when `cal_roll` bits 0, 1 and 2, respectively, are high at the loading edge. All of these flags are sticky.
- R7: At the loading edge, the alarm flag is set if all six bytes of `cal_next` equal the alarm fields.
- R8: `irq_alarm` is high exactly while the alarm flag and interrupt-enable bit 3 are both 1.
- R9: `irq_timer` is high for exactly the one cycle after each loading edge, provided interrupt-enable bit 2 was 1.
- R10: A write to a time field is ignored while busy is 1. Alarm writes are accepted at any time.
- R11: Time fields read their pre-update value throughout busy and change only at the edge where busy falls, apart from writes made while busy is 0.
- R12: Control keeps bits 0, 2 and 3 and reads 0 in the other bits. Interrupt enable keeps bits 2 and 3 and reads 0 elsewhere, so writing 0 disables both interrupts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle reference tick, used as a clock enable for the second divider |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| cal_now | output | 48 | Current time to the calendar core, seconds in bits 7:0 up to year in bits 47:40 |
| cal_next | input | 48 | Incremented time from the calendar core, same layout |
| cal_roll | input | 3 | Rollover flags from the core: minute, hour, day in bits 0, 1, 2 |
| irq_timer | output | 1 | Once-per-second interrupt pulse |
| irq_alarm | output | 1 | Alarm interrupt level |

## Verification
Read data is combinational. A write therefore shows up on `bus_rdata` in the cycle after the clock edge that samples it. Busy appears one edge after the tick that raises it. The time load, the busy fall and the `irq_timer` pulse all appear one edge after the clock edge that samples the last tick of a second. The sticky flags and `irq_alarm` follow in that same cycle. The bench drives inputs and compares at the falling edge, after its behavioural model has stepped on the rising edge. Every output is compared against the model's post-edge state, so each result is checked in exactly the cycle it is due. Directed checks wait on the model's busy state to place writes and reads inside and just after the guard window.

// File: rtl/rtcrf_pkg.sv
package rtcrf_pkg;
  localparam int FIELD_W    = 8;
  localparam int NUM_FIELDS = 6;
  localparam int SLOTS      = 8;
  localparam int CAL_W      = NUM_FIELDS * FIELD_W;

  localparam logic [2:0] BANK_TIME = 3'd0;
  localparam logic [2:0] BANK_ALM  = 3'd1;
  localparam logic [2:0] BANK_CFG  = 3'd2;

  localparam logic [2:0] SLOT_CTRL = 3'd0;
  localparam logic [2:0] SLOT_STAT = 3'd1;
  localparam logic [2:0] SLOT_IEN  = 3'd2;

  localparam int CTRL_RUN = 0;
  localparam int IEN_TMR  = 2;
  localparam int IEN_ALM  = 3;

  localparam logic [7:0] CTRL_KEEP = 8'h0D;
  localparam logic [7:0] IEN_KEEP  = 8'h0C;

  // sticky flag vector index (status bit minus 2)
  localparam int FL_SEC  = 0;
  localparam int FL_ALM  = 4;
  localparam int FL_PWR  = 5;
  localparam int FLAGS_W = 6;

  typedef logic [FIELD_W-1:0] rbyte_t;
endpackage

// File: rtl/rtcrf_sec_timer.sv
module rtcrf_sec_timer #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_tick,
  input  logic run,
  output logic busy,
  output logic upd
);
  localparam int CW = $clog2(TICKS_PER_SEC);
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);
  localparam logic [CW-1:0] WARN = CW'(TICKS_PER_SEC - 2);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_d, upd_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run) begin
      cnt_d = '0;
    end else if (ref_tick) begin
      cnt_d = (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
    end
    upd_d  = run & ref_tick & (cnt_q == LAST);
    busy_d = run & ((ref_tick & (cnt_q == WARN)) | (busy & ~upd));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      busy  <= 1'b0;
      upd   <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      busy  <= busy_d;
      upd   <= upd_d;
    end
  end
endmodule

// File: rtl/rtcrf_field_bank.sv
module rtcrf_field_bank
  import rtcrf_pkg::*;
#(
  parameter logic [2:0] BANK_ID = 3'd0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [5:0]       wr_idx,
  input  rbyte_t           wdata,
  input  logic             wr_block,
  input  logic             load,
  input  logic [CAL_W-1:0] load_val,
  output logic [CAL_W-1:0] fields
);
  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    rbyte_t q, d;
    logic   hit;

    always_comb begin
      hit = wr_en & ~wr_block & (wr_idx == {BANK_ID, 3'(g)});
      if (load) begin
        d = load_val[g*FIELD_W +: FIELD_W];
      end else if (hit) begin
        d = wdata;
      end else begin
        d = q;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end

    assign fields[g*FIELD_W +: FIELD_W] = q;
  end
endmodule

// File: rtl/rtcrf_status.sv
module rtcrf_status
  import rtcrf_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FLAGS_W-1:0] set_flags,
  input  logic [FLAGS_W-1:0] clr_flags,
  output logic [FLAGS_W-1:0] flags
);
  logic [FLAGS_W-1:0] flags_d;

  always_comb begin
    flags_d = (flags & ~clr_flags) | set_flags;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags         <= '0;
      flags[FL_PWR] <= 1'b1;
    end else begin
      flags <= flags_d;
    end
  end
endmodule

// File: rtl/rtc_regbank.sv
module rtc_regbank
  import rtcrf_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_tick,
  input  logic [7:0]       bus_addr,
  input  logic             bus_wr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  output logic [CAL_W-1:0] cal_now,
  input  logic [CAL_W-1:0] cal_next,
  input  logic [2:0]       cal_roll,
  output logic             irq_timer,
  output logic             irq_alarm
);
  logic [5:0]         idx;
  logic               addr_ok, wr_ok;
  logic               sec_busy, sec_upd;
  logic [CAL_W-1:0]   alm_fields;
  rbyte_t             time_arr [SLOTS];
  rbyte_t             alm_arr  [SLOTS];
  rbyte_t             ctrl_q, ctrl_d, ien_q, ien_d;
  logic [FLAGS_W-1:0] stat_flags, flag_set, flag_clr;
  logic               alarm_hit, irq_t_d;
  rbyte_t             stat_byte, rd_byte;

  assign idx     = bus_addr[7:2];
  assign addr_ok = (bus_addr[1:0] == 2'b00);
  assign wr_ok   = bus_wr & addr_ok;

  rtcrf_sec_timer #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_sec (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_tick (ref_tick),
    .run      (ctrl_q[CTRL_RUN]),
    .busy     (sec_busy),
    .upd      (sec_upd)
  );

  rtcrf_field_bank #(.BANK_ID(BANK_TIME)) u_time (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_ok),
    .wr_idx   (idx),
    .wdata    (bus_wdata),
    .wr_block (sec_busy),
    .load     (sec_upd),
    .load_val (cal_next),
    .fields   (cal_now)
  );

  rtcrf_field_bank #(.BANK_ID(BANK_ALM)) u_alarm (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_ok),
    .wr_idx   (idx),
    .wdata    (bus_wdata),
    .wr_block (1'b0),
    .load     (1'b0),
    .load_val ('0),
    .fields   (alm_fields)
  );

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    if (s < NUM_FIELDS) begin : g_used
      assign time_arr[s] = cal_now[s*FIELD_W +: FIELD_W];
      assign alm_arr[s]  = alm_fields[s*FIELD_W +: FIELD_W];
    end else begin : g_pad
      assign time_arr[s] = '0;
      assign alm_arr[s]  = '0;
    end
  end

  // alarm comparison against the value about to be loaded
  assign alarm_hit = (cal_next == alm_fields);

  always_comb begin
    flag_set = '0;
    if (sec_upd) begin
      flag_set = {1'b0, alarm_hit, cal_roll, 1'b1};
    end
    flag_clr = '0;
    if (wr_ok && idx == {BANK_CFG, SLOT_STAT}) begin
      flag_clr = bus_wdata[7:2];
    end
  end

  rtcrf_status u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_flags (flag_set),
    .clr_flags (flag_clr),
    .flags     (stat_flags)
  );

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ok && idx == {BANK_CFG, SLOT_CTRL}) ctrl_d = bus_wdata & CTRL_KEEP;
    ien_d = ien_q;
    if (wr_ok && idx == {BANK_CFG, SLOT_IEN}) ien_d = bus_wdata & IEN_KEEP;
    irq_t_d = sec_upd & ien_q[IEN_TMR];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      ien_q     <= '0;
      irq_timer <= 1'b0;
    end else begin
      ctrl_q    <= ctrl_d;
      ien_q     <= ien_d;
      irq_timer <= irq_t_d;
    end
  end

  assign irq_alarm = stat_flags[FL_ALM] & ien_q[IEN_ALM];
  assign stat_byte = {stat_flags, ctrl_q[CTRL_RUN], sec_busy};

  always_comb begin
    rd_byte = '0;
    if (addr_ok) begin
      case (idx[5:3])
        BANK_TIME: rd_byte = time_arr[idx[2:0]];
        BANK_ALM:  rd_byte = alm_arr[idx[2:0]];
        BANK_CFG: begin
          case (idx[2:0])
            SLOT_CTRL: rd_byte = ctrl_q;
            SLOT_STAT: rd_byte = stat_byte;
            SLOT_IEN:  rd_byte = ien_q;
            default:   rd_byte = '0;
          endcase
        end
        default: rd_byte = '0;
      endcase
    end
  end

  assign bus_rdata = rd_byte;
endmodule

// File: rtl/rtcrf_checker.sv
module rtcrf_checker
  import rtcrf_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       bus_addr,
  input logic             bus_wr,
  input logic             clr_sec_bit,
  input logic             busy,
  input logic             upd,
  input logic             sec_flag,
  input logic             alm_flag,
  input logic             pwr_flag,
  input logic [CAL_W-1:0] cal_now,
  input logic             irq_timer
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  AST_TIME_FROZEN_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && busy && $past(busy)) |-> $stable(cal_now)); // R11

  AST_TIMER_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_timer |=> !irq_timer); // R9

  AST_TIMER_AT_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && irq_timer) |-> (!busy && $past(busy))); // R3

  AST_ALARM_ONLY_ON_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $rose(alm_flag)) |-> $past(upd)); // R7

  AST_PWR_STAYS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_flag |=> !pwr_flag); // R5

  AST_SEC_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_flag && !(bus_wr && bus_addr == 8'h44 && clr_sec_bit)) |=> sec_flag); // R6

  AST_BUSY_BLOCKS_TIME_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_wr && bus_addr < 8'h18 && !upd) |=> $stable(cal_now)); // R10
endmodule

bind rtc_regbank rtcrf_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_addr    (bus_addr),
  .bus_wr      (bus_wr),
  .clr_sec_bit (bus_wdata[2]),
  .busy        (sec_busy),
  .upd         (sec_upd),
  .sec_flag    (stat_flags[0]),
  .alm_flag    (stat_flags[4]),
  .pwr_flag    (stat_flags[5]),
  .cal_now     (cal_now),
  .irq_timer   (irq_timer)
);

// File: tb/rtc_regbank_test.sv
module rtc_regbank_test;
  localparam int TPS = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic [47:0] cal_now, cal_next;
  logic [2:0]  cal_roll;
  logic        irq_timer, irq_alarm;

  int n_checks = 0;
  int n_fails = 0;
  bit finished = 1'b0;
  bit tick_on = 1'b0;
  int tick_div = 0;

  always #2 clk = ~clk;

  rtc_regbank #(.TICKS_PER_SEC(TPS)) uut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cal_now(cal_now), .cal_next(cal_next),
    .cal_roll(cal_roll), .irq_timer(irq_timer), .irq_alarm(irq_alarm)
  );

  // ---------------- calendar core stand-in ----------------
  function automatic logic [8:0] bcd_inc(input logic [7:0] v, input logic [7:0] last,
                                         input logic [7:0] first);
    if (v == last) return {1'b1, first};
    if (v[3:0] == 4'd9) return {1'b0, v[7:4] + 4'd1, 4'd0};
    return {1'b0, v + 8'd1};
  endfunction

  function automatic logic [50:0] next_cal(input logic [47:0] t);
    logic [8:0] s, m, h, d;
    s = bcd_inc(t[7:0], 8'h59, 8'h00);
    m = s[8] ? bcd_inc(t[15:8], 8'h59, 8'h00) : {1'b0, t[15:8]};
    h = m[8] ? bcd_inc(t[23:16], 8'h23, 8'h00) : {1'b0, t[23:16]};
    d = h[8] ? bcd_inc(t[31:24], 8'h31, 8'h01) : {1'b0, t[31:24]};
    return {h[8], m[8], s[8], t[47:32], d[7:0], h[7:0], m[7:0], s[7:0]};
  endfunction

  assign {cal_roll, cal_next} = next_cal(cal_now);

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_time [6];
  logic [7:0] m_alm  [6];
  logic [7:0] m_ctrl, m_ien, m_flags;
  int         m_cnt;
  bit         m_busy, m_upd, m_irqt;
  logic [50:0] mdl_nxt;
  logic [7:0]  mdl_set, mdl_clr;
  int          mdl_idx;
  bit          mdl_run, nb, nu;
  int          nc;

  function automatic logic [47:0] pack6(input logic [7:0] a [6]);
    logic [47:0] r;
    for (int i = 0; i < 6; i++) r[i*8 +: 8] = a[i];
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 6; i++) begin m_time[i] = 8'h00; m_alm[i] = 8'h00; end
      m_ctrl = 8'h00; m_ien = 8'h00; m_flags = 8'h80;
      m_cnt = 0; m_busy = 0; m_upd = 0; m_irqt = 0;
    end else begin
      mdl_nxt = next_cal(pack6(m_time));
      mdl_idx = int'(bus_addr[7:2]);
      mdl_run = m_ctrl[0];
      nu = mdl_run && ref_tick && (m_cnt == TPS - 1);
      nb = mdl_run && ((ref_tick && m_cnt == TPS - 2) || (m_busy && !m_upd));
      nc = !mdl_run ? 0 : (ref_tick ? ((m_cnt == TPS - 1) ? 0 : m_cnt + 1) : m_cnt);
      mdl_set = 8'h00;
      if (m_upd) begin
        mdl_set[2] = 1'b1;
        mdl_set[5:3] = mdl_nxt[50:48];
        mdl_set[6] = (mdl_nxt[47:0] == pack6(m_alm));
      end
      mdl_clr = (bus_wr && bus_addr == 8'h44) ? (bus_wdata & 8'hFC) : 8'h00;
      m_flags = (m_flags & ~mdl_clr) | mdl_set;
      m_irqt = m_upd && m_ien[2];
      if (m_upd) begin
        for (int i = 0; i < 6; i++) m_time[i] = mdl_nxt[i*8 +: 8];
      end else if (bus_wr && bus_addr[1:0] == 2'b00 && mdl_idx < 6 && !m_busy) begin
        m_time[mdl_idx] = bus_wdata;
      end
      if (bus_wr && bus_addr[1:0] == 2'b00 && mdl_idx >= 8 && mdl_idx < 14)
        m_alm[mdl_idx - 8] = bus_wdata;
      if (bus_wr && bus_addr == 8'h40) m_ctrl = bus_wdata & 8'h0D;
      if (bus_wr && bus_addr == 8'h48) m_ien = bus_wdata & 8'h0C;
      m_cnt = nc; m_busy = nb; m_upd = nu;
    end
  end

  function automatic logic [7:0] model_read(input logic [7:0] a);
    int i;
    i = int'(a[7:2]);
    if (a[1:0] != 2'b00) return 8'h00;
    if (i < 6) return m_time[i];
    if (i >= 8 && i < 14) return m_alm[i - 8];
    if (i == 16) return m_ctrl;
    if (i == 17) return {m_flags[7:2], m_ctrl[0], m_busy};
    if (i == 18) return m_ien;
    return 8'h00;
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    int i;
    i = int'(a[7:2]);
    if (a[1:0] != 2'b00) return "R2";
    if (i < 6) return "R11";
    if (i == 16 || i == 18) return "R12";
    if (i == 17) return "R4";
    return "R2";
  endfunction

  // ---------------- checking helpers ----------------
  task automatic chk(input bit ok, input string req, input logic [47:0] act,
                     input logic [47:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic [7:0] a, input bit w, input logic [7:0] d);
    bus_addr  = a;
    bus_wr    = w;
    bus_wdata = d;
    ref_tick  = tick_on && (tick_div == 0);
    tick_div  = (tick_div + 1) % 3;
    @(posedge clk);
    @(negedge clk);
    chk(bus_rdata == model_read(bus_addr), tag_of(bus_addr),
        48'(bus_rdata), 48'(model_read(bus_addr)));
    chk(irq_timer == m_irqt, "R9", 48'(irq_timer), 48'(m_irqt));
    chk(irq_alarm == (m_flags[6] & m_ien[3]), "R8", 48'(irq_alarm),
        48'(m_flags[6] & m_ien[3]));
    chk(cal_now == pack6(m_time), "R3", cal_now, pack6(m_time));
  endtask

  task automatic rd(input logic [7:0] a);
    cyc(a, 1'b0, 8'h00);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    cyc(a, 1'b1, d);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  logic [7:0] sec0;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h44); chk(bus_rdata == 8'h80, "R1", 48'(bus_rdata), 48'h80);
    rd(8'h40); chk(bus_rdata == 8'h00, "R1", 48'(bus_rdata), 48'h00);
    rd(8'h48); chk(bus_rdata == 8'h00, "R1", 48'(bus_rdata), 48'h00);
    chk(cal_now == 48'h0 && !irq_timer && !irq_alarm, "R1", cal_now, 48'h0);

    // R2 address map
    wr(8'h24, 8'h42); rd(8'h24); chk(bus_rdata == 8'h42, "R2", 48'(bus_rdata), 48'h42);
    wr(8'h10, 8'h07); rd(8'h10); chk(bus_rdata == 8'h07, "R2", 48'(bus_rdata), 48'h07);
    chk(cal_now[39:32] == 8'h07, "R2", cal_now, 48'h0700000000);
    wr(8'h5C, 8'hAA); rd(8'h5C); chk(bus_rdata == 8'h00, "R2", 48'(bus_rdata), 48'h00);
    wr(8'h05, 8'h33); rd(8'h04); chk(bus_rdata == 8'h00, "R2", 48'(bus_rdata), 48'h00);
    rd(8'h18); chk(bus_rdata == 8'h00, "R2", 48'(bus_rdata), 48'h00);

    // R12 masks, R4 run mirror
    wr(8'h40, 8'hFF); rd(8'h40); chk(bus_rdata == 8'h0D, "R12", 48'(bus_rdata), 48'h0D);
    rd(8'h44); chk(bus_rdata == 8'h82, "R4", 48'(bus_rdata), 48'h82);
    wr(8'h40, 8'h00);
    wr(8'h48, 8'hFF); rd(8'h48); chk(bus_rdata == 8'h0C, "R12", 48'(bus_rdata), 48'h0C);
    wr(8'h48, 8'h00); rd(8'h48); chk(bus_rdata == 8'h00, "R12", 48'(bus_rdata), 48'h00);

    // set 23:59:58 day 05 month 03 year 24, alarm at the day rollover
    wr(8'h00, 8'h58); wr(8'h04, 8'h59); wr(8'h08, 8'h23);
    wr(8'h0C, 8'h05); wr(8'h10, 8'h03); wr(8'h14, 8'h24);
    wr(8'h20, 8'h00); wr(8'h24, 8'h00); wr(8'h28, 8'h00);
    wr(8'h2C, 8'h06); wr(8'h30, 8'h03); wr(8'h34, 8'h24);
    wr(8'h48, 8'h0C);
    tick_on = 1'b1; tick_div = 0;
    wr(8'h40, 8'h01);
    for (int i = 0; i < 30; i++) rd(8'h00);

    // R6 / R7 / R8 after the rollover into the alarm time
    chk(cal_now[31:0] == 32'h06000000, "R6", cal_now, 48'h240306000000);
    chk(irq_alarm == 1'b1, "R7", 48'(irq_alarm), 48'h1);
    rd(8'h44); chk((bus_rdata & 8'hFC) == 8'hFC, "R6", 48'(bus_rdata), 48'hFC);

    // R5 write-one-to-clear
    wr(8'h44, 8'h00); chk((bus_rdata & 8'hFC) == 8'hFC, "R5", 48'(bus_rdata), 48'hFC);
    wr(8'h44, 8'hC0); chk((bus_rdata & 8'hC0) == 8'h00, "R5", 48'(bus_rdata), 48'h00);
    chk(irq_alarm == 1'b0, "R8", 48'(irq_alarm), 48'h0);

    // R10 time write inside busy is dropped
    for (int i = 0; i < 40 && !m_busy; i++) rd(8'h44);
    wr(8'h00, 8'h77);
    chk(bus_rdata != 8'h77, "R10", 48'(bus_rdata), 48'(m_time[0]));
    wr(8'h28, 8'h15); rd(8'h28); chk(bus_rdata == 8'h15, "R10", 48'(bus_rdata), 48'h15);

    // R11 reads inside busy stay on the old second, then advance
    for (int i = 0; i < 40 && m_busy; i++) rd(8'h00);
    for (int i = 0; i < 40 && !m_busy; i++) rd(8'h00);
    sec0 = bus_rdata;
    for (int i = 0; i < 40 && m_busy; i++) begin
      rd(8'h00);
      if (m_busy) chk(bus_rdata == sec0, "R11", 48'(bus_rdata), 48'(sec0));
    end
    chk(bus_rdata == bcd_inc(sec0, 8'h59, 8'h00) & 9'h0FF, "R11", 48'(bus_rdata),
        48'(bcd_inc(sec0, 8'h59, 8'h00) & 9'h0FF));

    // R3 stop freezes time and drops busy
    for (int i = 0; i < 40 && !m_busy; i++) rd(8'h44);
    wr(8'h40, 8'h00);
    rd(8'h44); chk(bus_rdata[1:0] == 2'b00, "R3", 48'(bus_rdata), 48'h0);
    sec0 = cal_now[7:0];
    for (int i = 0; i < 30; i++) rd(8'h00);
    chk(cal_now[7:0] == sec0, "R3", cal_now, 48'(sec0));

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule